// File: doc/BRIEF.md
# Multicast Contention Resolution Unit

This block sits in an input port controller of a grouped-output packet switch. The block decides, once per cell cycle, which output groups a head-of-line multicast cell has reached. Each output group sends back one serial priority stream. The block turns every stream into a 16-bit number and compares that number with the local priority of the cell. A group the cell won has its bit cleared in the multicast pattern. When any pattern bit is still set after this step, the block asks for the cell to be sent again in the next cell cycle, using the reduced pattern.

A lower priority level has a numerically larger value. A feedback value that is equal to or larger than the local priority therefore means the cell took the routing link in that group. The `PARALLEL` parameter picks between two variants:
- one comparator per group, all groups settled in a single cycle;
- a single shared comparator, walked over the groups one per cycle.

Control is a four-state machine:
- `ST_IDLE`: waits for a frame start. Goes to `ST_SHIFT` on `fb_start`.
- `ST_SHIFT`: collects 16 bits per stream. Goes to `ST_COMPARE` after the last bit.
- `ST_COMPARE`: clears the groups that were won. In parallel mode it lasts one cycle. In sequential mode it lasts one cycle per group, then goes to `ST_FINISH`.
- `ST_FINISH`: presents the verdict for one cycle, then returns to `ST_IDLE`.

Top module: `mcast_resolver`

## Requirements
- R1: After reset, `pattern_out` is all zeros and `done` and `resend` are low.
- R2: When `load_valid` is high and no resolution is in progress (state `ST_IDLE` or `ST_FINISH`), `pattern_out` equals `load_pattern` from the next cycle on. `load_prio` is kept as the local priority.
- R3: Each feedback stream is taken most significant bit first. The bit on `fb_bit[j]` is sampled in the cycle where `fb_start` is high and in each of the following 15 cycles, giving a 16-bit value for group j (bit j of the pattern).
- R4: Pattern bit j is cleared when the feedback value of group j is greater than or equal to the latched local priority. The bit is kept when that value is smaller.
- R5: A pattern bit that is already 0 stays 0, whatever feedback its group returns.
- R6: `done` is high for exactly one cycle. If `fb_start` is sampled in cycle 0, `done` is high in cycle 17 in parallel mode and in cycle 16+K in sequential mode, where K is the number of groups.
- R7: While `done` is high, `resend` is high exactly when the reduced pattern is nonzero. `pattern_out` keeps the reduced pattern, so a further cell cycle without a new load reduces it again.
- R8: While in `ST_SHIFT` or `ST_COMPARE`, `load_valid` and `fb_start` have no effect on the result.
- R9: Sequential mode visits the groups in order 0 to K-1, one per cycle. Its final pattern and resend are the same as in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_valid | input | 1 | Load a new head-of-line cell |
| load_pattern | input | GROUPS | Initial multicast pattern of the new cell |
| load_prio | input | PRIO_W | Local priority of the new cell |
| fb_start | input | 1 | Marks the cycle carrying the first feedback bit |
| fb_bit | input | GROUPS | One serial feedback bit per output group |
| pattern_out | output | GROUPS | Current (reduced) multicast pattern |
| resend | output | 1 | Cell must be sent again; valid with done |
| done | output | 1 | One-cycle pulse ending a resolution |

## Verification
A fault in the shift state or its bit counter shows up at the ports as a shifted or misaligned feedback value. That error flips the keep-or-clear decision only for feedback values that sit close to the local priority, so the bench uses values one step apart and values whose order reverses when the bit order is reversed. A stuck or skipped state shows up straight away as `done` arriving in the wrong cycle. A bad group index in the sequential walk leaves a wrong bit in `pattern_out` at the `done` pulse, so the bench compares the two variants bit for bit on the same stimulus.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_COMPARE = 2'd2,
        ST_FINISH  = 2'd3
    } mcr_state_e;
endpackage

// File: rtl/mcr_deser.sv
module mcr_deser #(
    parameter int GROUPS = 16,
    parameter int PRIO_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           shift_en,
    input  logic [GROUPS-1:0]              fb_bit,
    output logic [GROUPS-1:0][PRIO_W-1:0]  fb_val
);
    // One shift register per group; first bit ends up most significant.
    for (genvar g = 0; g < GROUPS; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fb_val[g] <= '0;
            end else if (shift_en) begin
                fb_val[g] <= {fb_val[g][PRIO_W-2:0], fb_bit[g]};
            end
        end
    end
endmodule

// File: rtl/mcr_ctrl.sv
module mcr_ctrl
    import mcr_pkg::*;
#(
    parameter int GROUPS   = 16,
    parameter int PRIO_W   = 16,
    parameter int PARALLEL = 1,
    localparam int CW      = $clog2(PRIO_W),
    localparam int IW      = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fb_start,
    input  logic          load_valid,
    output logic          shift_en,
    output logic          cmp_en,
    output logic [IW-1:0] cmp_idx,
    output logic          load_en,
    output logic          busy,
    output logic          done
);
    mcr_state_e state_q, state_d;
    logic [CW-1:0] bit_cnt;
    logic [IW-1:0] grp_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (fb_start) state_d = ST_SHIFT;
            ST_SHIFT:   if (bit_cnt == CW'(PRIO_W - 1)) state_d = ST_COMPARE;
            ST_COMPARE: if (PARALLEL != 0 || grp_cnt == IW'(GROUPS - 1)) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Bit and group counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            grp_cnt <= '0;
        end else begin
            if (state_q == ST_IDLE && fb_start) begin
                bit_cnt <= CW'(1);
            end else if (state_q == ST_SHIFT) begin
                bit_cnt <= bit_cnt + CW'(1);
            end
            if (state_q == ST_COMPARE) begin
                grp_cnt <= grp_cnt + IW'(1);
            end else begin
                grp_cnt <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        shift_en = 1'b0;
        cmp_en   = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:    shift_en = fb_start;
            ST_SHIFT:   begin shift_en = 1'b1; busy = 1'b1; end
            ST_COMPARE: begin cmp_en = 1'b1; busy = 1'b1; end
            ST_FINISH:  done = 1'b1;
            default:    ;
        endcase
        cmp_idx = grp_cnt;
        load_en = load_valid && !busy;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q) == ST_COMPARE); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && fb_start) |=> state_q != ST_SHIFT); // R8
endmodule

// File: rtl/mcr_pattern.sv
module mcr_pattern #(
    parameter int GROUPS   = 16,
    parameter int PRIO_W   = 16,
    parameter int PARALLEL = 1,
    localparam int IW      = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic [GROUPS-1:0]             load_pattern,
    input  logic [PRIO_W-1:0]             load_prio,
    input  logic                          cmp_en,
    input  logic [IW-1:0]                 cmp_idx,
    input  logic [GROUPS-1:0][PRIO_W-1:0] fb_val,
    output logic [GROUPS-1:0]             pattern
);
    logic [PRIO_W-1:0] lp_q;
    logic [GROUPS-1:0] clr_mask;

    if (PARALLEL != 0) begin : g_par
        // One comparator per group
        for (genvar g = 0; g < GROUPS; g++) begin : g_cmp
            assign clr_mask[g] = cmp_en && (fb_val[g] >= lp_q);
        end
    end else begin : g_seq
        // One shared comparator steered by the group index
        logic [PRIO_W-1:0] sel_val;
        logic              won;
        assign sel_val = fb_val[cmp_idx];
        assign won     = sel_val >= lp_q;
        always_comb begin
            clr_mask = '0;
            clr_mask[cmp_idx] = cmp_en && won;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern <= '0;
            lp_q    <= '0;
        end else if (load_en) begin
            pattern <= load_pattern;
            lp_q    <= load_prio;
        end else begin
            pattern <= pattern & ~clr_mask;
        end
    end

    AST_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (pattern & ~$past(pattern)) == '0); // R5
endmodule

// File: rtl/mcast_resolver.sv
module mcast_resolver #(
    parameter int GROUPS   = 16,
    parameter int PRIO_W   = 16,
    parameter int PARALLEL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [GROUPS-1:0] load_pattern,
    input  logic [PRIO_W-1:0] load_prio,
    input  logic              fb_start,
    input  logic [GROUPS-1:0] fb_bit,
    output logic [GROUPS-1:0] pattern_out,
    output logic              resend,
    output logic              done
);
    localparam int IW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    logic                          shift_en;
    logic                          cmp_en;
    logic [IW-1:0]                 cmp_idx;
    logic                          load_en;
    logic                          busy;
    logic [GROUPS-1:0][PRIO_W-1:0] fb_val;

    mcr_ctrl #(.GROUPS(GROUPS), .PRIO_W(PRIO_W), .PARALLEL(PARALLEL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fb_start(fb_start), .load_valid(load_valid),
        .shift_en(shift_en), .cmp_en(cmp_en), .cmp_idx(cmp_idx),
        .load_en(load_en), .busy(busy), .done(done)
    );

    mcr_deser #(.GROUPS(GROUPS), .PRIO_W(PRIO_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .fb_bit(fb_bit), .fb_val(fb_val)
    );

    mcr_pattern #(.GROUPS(GROUPS), .PRIO_W(PRIO_W), .PARALLEL(PARALLEL)) u_pattern (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_pattern(load_pattern),
        .load_prio(load_prio), .cmp_en(cmp_en), .cmp_idx(cmp_idx),
        .fb_val(fb_val), .pattern(pattern_out)
    );

    assign resend = done && (pattern_out != '0);

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !busy) |=> pattern_out == $past(load_pattern)); // R2
    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmp_en) |=> $stable(pattern_out)); // R8
endmodule

// File: tb/test_mcast_resolver.sv
module test_mcast_resolver;
    localparam int G = 16;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_valid = 1'b0;
    logic [G-1:0] load_pattern = '0;
    logic [W-1:0] load_prio = '0;
    logic         fb_start = 1'b0;
    logic [G-1:0] fb_bit = '0;
    logic [G-1:0] pat_p, pat_s;
    logic         res_p, res_s, done_p, done_s;

    int total = 0;
    int bad = 0;
    logic [W-1:0] fbv [G];
    logic [G-1:0] cur_pat;
    logic [W-1:0] cur_lp;

    always #4 clk = ~clk; // 125 MHz

    mcast_resolver #(.GROUPS(G), .PRIO_W(W), .PARALLEL(1)) i_mcast_resolver (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_pattern(load_pattern),
        .load_prio(load_prio), .fb_start(fb_start), .fb_bit(fb_bit),
        .pattern_out(pat_p), .resend(res_p), .done(done_p)
    );

    mcast_resolver #(.GROUPS(G), .PRIO_W(W), .PARALLEL(0)) i_mcast_resolver_seq (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_pattern(load_pattern),
        .load_prio(load_prio), .fb_start(fb_start), .fb_bit(fb_bit),
        .pattern_out(pat_s), .resend(res_s), .done(done_s)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [G-1:0] expect_pat(input logic [G-1:0] p, input logic [W-1:0] lp);
        logic [G-1:0] r = p;
        for (int j = 0; j < G; j++) if (fbv[j] >= lp) r[j] = 1'b0;
        return r;
    endfunction

    task automatic do_load(input logic [G-1:0] p, input logic [W-1:0] lp);
        @(negedge clk);
        load_valid = 1'b1; load_pattern = p; load_prio = lp;
        @(negedge clk);
        load_valid = 1'b0;
        cur_pat = p; cur_lp = lp;
        check("R2 load parallel", 32'(pat_p), 32'(p));
        check("R2 load sequential", 32'(pat_s), 32'(p));
    endtask

    // Shift one cell cycle of feedback; optional disturbances while busy (R8)
    task automatic run_cycle(input bit disturb);
        logic [G-1:0] exp;
        exp = expect_pat(cur_pat, cur_lp);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            fb_start = (i == 0) || (disturb && i == 8);
            for (int j = 0; j < G; j++) fb_bit[j] = fbv[j][W-1-i];
            if (disturb && i == 5) begin
                load_valid = 1'b1; load_pattern = ~cur_pat; load_prio = '0;
            end else begin
                load_valid = 1'b0;
            end
        end
        @(negedge clk);
        fb_start = 1'b0; fb_bit = '0; load_valid = 1'b0;
        check("R6 no early done", 32'(done_p), 32'd0);
        for (int c = 1; c <= G; c++) begin
            if (disturb && c == 2) fb_start = 1'b1;
            @(negedge clk);
            check("R6 parallel done timing", 32'(done_p), 32'(c == 1));
            check("R9 sequential done timing", 32'(done_s), 32'(c == G));
            if (c == 1) begin
                check("R4 parallel pattern", 32'(pat_p), 32'(exp));
                check("R7 parallel resend", 32'(res_p), 32'(exp != '0));
            end
            if (c == G) begin
                check("R9 sequential pattern", 32'(pat_s), 32'(exp));
                check("R7 sequential resend", 32'(res_s), 32'(exp != '0));
            end
        end
        fb_start = 1'b0;
        @(negedge clk);
        check("R6 done drops", 32'(done_s), 32'd0);
        cur_pat = exp;
    endtask

    task automatic t_reset();
        check("R1 pattern", 32'(pat_p), 32'd0);
        check("R1 done", 32'(done_p), 32'd0);
        check("R1 resend", 32'(res_p), 32'd0);
        check("R1 seq pattern", 32'(pat_s), 32'd0);
    endtask

    task automatic t_all_won();
        do_load(16'hFFFF, 16'h0100);
        for (int j = 0; j < G; j++) fbv[j] = 16'hFFFF;
        run_cycle(0);
        check("R7 all cleared", 32'(pat_p), 32'd0);
    endtask

    task automatic t_mixed_and_retry();
        do_load(16'hA5F3, 16'h4000);
        for (int j = 0; j < G; j++)
            fbv[j] = (j % 3 == 0) ? 16'h4000 : ((j % 3 == 1) ? 16'h3FFF : 16'h4001); // R4 edges
        run_cycle(0);
        // R7 retransmission with reduced pattern, no reload
        for (int j = 0; j < G; j++) fbv[j] = (j < 8) ? 16'hFFFF : 16'h0000;
        run_cycle(0);
    endtask

    task automatic t_zero_bits();
        do_load(16'h00F0, 16'h8000);
        for (int j = 0; j < G; j++) fbv[j] = 16'h0001; // R5: losers everywhere
        run_cycle(0);
        check("R5 zero bits stay", 32'(pat_p & ~16'h00F0), 32'd0);
    endtask

    task automatic t_msb_first();
        do_load(16'h0003, 16'h8000);
        fbv[0] = 16'h0001; fbv[1] = 16'h8000; // R3: reversing the order flips both
        for (int j = 2; j < G; j++) fbv[j] = 16'h0000;
        run_cycle(0);
        check("R3 msb first", 32'(pat_p), 32'h1);
    endtask

    task automatic t_busy_ignore();
        do_load(16'h5A5A, 16'h1234);
        for (int j = 0; j < G; j++) fbv[j] = 16'h1200 + 16'(j * 8);
        run_cycle(1); // R8
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_won();
        t_mixed_and_retry();
        t_zero_bits();
        t_msb_first();
        t_busy_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule